// File: doc/BRIEF.md
# Parallel Port Extended Control Register

This block holds the extended control byte of an enhanced parallel port that moves data through a byte FIFO. Software sees one 8-bit register. It holds four writable fields:

- a 3-bit port mode;
- a fault-interrupt disable bit;
- a DMA enable bit;
- a service flag.

It also holds two read-only FIFO status bits. The block watches the FIFO level, the transfer direction, a DMA terminal-count pulse and the active-low fault line. From these it raises single-cycle interrupt pulses and gates the DMA request.

The service flag is driven by a two-state machine.

- **SVC_MASKED** (flag reads 1): DMA and service interrupts are held off.
  - Transition *arm*: a register write with bit 2 = 0 moves the machine to SVC_ARMED.
- **SVC_ARMED** (flag reads 0): the machine waits for a service condition.
  - Transition *service*: the active service condition is true and no write occurs that cycle. The machine emits one `svc_irq` pulse and returns to SVC_MASKED.
  - Transition *mask*: a write with bit 2 = 1 returns the machine to SVC_MASKED without a pulse.

The active service condition depends on the DMA enable and the direction:

| DMA enable | Direction | Service condition |
|---|---|---|
| 1 | any | terminal-count pulse |
| 0 | output | free space ≥ write threshold |
| 0 | input | FIFO level ≥ read threshold |

The fault line passes through a two-flop synchronizer before its falling edge is detected.

Top module: `ppx_ctl_reg`

## Requirements
- R1: After reset the register reads mode 000, bit 4 = 0, bit 3 = 0, bit 2 = 1. With the FIFO empty the read value is 0x05, and both interrupt outputs are low.
- R2: Bits 7:5 are a read/write mode field, and `mode_sel` shows the stored value.
- R3: Bit 1 (full) reads 1 when the FIFO level equals DEPTH. Bit 0 (empty) reads 1 when the level is 0. Writes to bits 1:0 have no effect.
- R4: `dma_en` follows bit 3. `dma_req_gate` is 1 only while bit 3 = 1 and bit 2 = 0.
- R5: While bit 4 = 0 and the mode is ECP (011), each falling edge of `fault_n` gives one `fault_irq` pulse. No pulse occurs when bit 4 = 1 or when another mode is selected.
- R6: Writing bit 4 from 1 to 0 with mode 011 while `fault_n` is low gives one `fault_irq` pulse. Writing 0 over a 0 gives none.
- R7: With bit 3 = 1 and bit 2 = 0, a terminal-count pulse sets bit 2 and gives one `svc_irq` pulse.
- R8: With bit 3 = 0 and direction output (`dir_in` = 0), bit 2 = 0 is set and pulses once DEPTH minus level is at least `wr_thresh`.
- R9: With bit 3 = 0 and direction input (`dir_in` = 1), bit 2 = 0 is set and pulses once the level is at least `rd_thresh`.
- R10: While bit 2 = 1 no `svc_irq` pulse occurs, and writing 1 to bit 2 never causes one, even with a service condition true.
- R11: `svc_irq` and `fault_irq` are each high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read value of the register |
| fifo_level | input | CNT_W | Bytes held in the FIFO, 0..DEPTH |
| dir_in | input | 1 | 1 = input direction, 0 = output direction |
| wr_thresh | input | CNT_W | Free-byte threshold, 1..DEPTH |
| rd_thresh | input | CNT_W | Valid-byte threshold, 1..DEPTH |
| tc_pulse | input | 1 | DMA terminal-count pulse |
| fault_n | input | 1 | Asynchronous active-low fault line |
| mode_sel | output | 3 | Stored port mode |
| dma_en | output | 1 | DMA enable bit |
| dma_req_gate | output | 1 | DMA may run |
| svc_irq | output | 1 | Service interrupt pulse |
| fault_irq | output | 1 | Fault interrupt pulse |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |

## Verification
The hardest case to reach is the lost-event rescue. The fault line must already be low and fully synchronized, with its falling edge deliberately masked, at the moment software clears bit 4.

The stimulus gets there as follows:
1. Select ECP mode with bit 4 set.
2. Drop `fault_n` and let several cycles pass, so that no edge remains pending.
3. Write bit 4 to 0, and count pulses starting at the edge of that write.

A repeat of the same write then shows that only a 1-to-0 change triggers the pulse.

// File: rtl/ppx_pkg.sv
package ppx_pkg;
    typedef enum logic {
        SVC_ARMED  = 1'b0,
        SVC_MASKED = 1'b1
    } svc_state_e;

    localparam int MODE_HI  = 7;
    localparam int MODE_LO  = 5;
    localparam int FDIS_BIT = 4;
    localparam int DMA_BIT  = 3;
    localparam int SVC_BIT  = 2;
endpackage

// File: rtl/ppx_fault_edge.sv
module ppx_fault_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n,
    input  logic irq_dis,
    input  logic is_ecp,
    input  logic clr_evt,
    output logic fault_irq
);
    logic s1_q, s2_q, prev_q, irq_q;
    logic fell;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= fault_n;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign fell = prev_q & ~s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (fell & ~irq_dis & is_ecp) | (clr_evt & ~s2_q);
    end

    assign fault_irq = irq_q;

    // R11
    fault_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |=> !fault_irq);

    // R5
    fault_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_irq) |-> $past(is_ecp || clr_evt));
endmodule

// File: rtl/ppx_svc_fsm.sv
module ppx_svc_fsm
    import ppx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_flag,
    input  logic cond,
    output logic flag,
    output logic svc_irq
);
    svc_state_e state_q, state_d;
    logic irq_q;

    always_comb begin
        state_d = state_q;
        if (wr) begin
            state_d = wr_flag ? SVC_MASKED : SVC_ARMED;
        end else begin
            unique case (state_q)
                SVC_ARMED:  if (cond) state_d = SVC_MASKED;
                SVC_MASKED: state_d = SVC_MASKED;
                default:    state_d = SVC_MASKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_MASKED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= !wr && (state_q == SVC_ARMED) && cond;
    end

    assign flag    = (state_q == SVC_MASKED);
    assign svc_irq = irq_q;

    // R11
    svc_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |=> !svc_irq);

    // R7
    svc_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_irq && !$past(wr)) |-> flag);

    // R10
    svc_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SVC_MASKED) |=> !svc_irq);
endmodule

// File: rtl/ppx_ctl_reg.sv
module ppx_ctl_reg
    import ppx_pkg::*;
#(
    parameter int       DEPTH    = 16,
    parameter logic [2:0] ECP_MODE = 3'b011,
    parameter int       CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [CNT_W-1:0] fifo_level,
    input  logic             dir_in,
    input  logic [CNT_W-1:0] wr_thresh,
    input  logic [CNT_W-1:0] rd_thresh,
    input  logic             tc_pulse,
    input  logic             fault_n,
    output logic [2:0]       mode_sel,
    output logic             dma_en,
    output logic             dma_req_gate,
    output logic             svc_irq,
    output logic             fault_irq,
    output logic             fifo_full,
    output logic             fifo_empty
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [2:0]       mode_q;
    logic             fdis_q, dma_q;
    logic             svc_flag, svc_cond, clr_evt;
    logic [CNT_W-1:0] free_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 3'b000;
            fdis_q <= 1'b0;
            dma_q  <= 1'b0;
        end else if (reg_wr) begin
            mode_q <= reg_wdata[MODE_HI:MODE_LO];
            fdis_q <= reg_wdata[FDIS_BIT];
            dma_q  <= reg_wdata[DMA_BIT];
        end
    end

    assign free_cnt   = DEPTH_C - fifo_level;
    assign fifo_full  = (fifo_level >= DEPTH_C);
    assign fifo_empty = (fifo_level == '0);

    always_comb begin
        if (dma_q)       svc_cond = tc_pulse;
        else if (dir_in) svc_cond = (fifo_level >= rd_thresh);
        else             svc_cond = (free_cnt >= wr_thresh);
    end

    assign clr_evt = reg_wr && fdis_q && !reg_wdata[FDIS_BIT]
                     && (reg_wdata[MODE_HI:MODE_LO] == ECP_MODE);

    ppx_svc_fsm u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wr_flag (reg_wdata[SVC_BIT]),
        .cond    (svc_cond),
        .flag    (svc_flag),
        .svc_irq (svc_irq)
    );

    ppx_fault_edge u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_n   (fault_n),
        .irq_dis   (fdis_q),
        .is_ecp    (mode_q == ECP_MODE),
        .clr_evt   (clr_evt),
        .fault_irq (fault_irq)
    );

    assign mode_sel     = mode_q;
    assign dma_en       = dma_q;
    assign dma_req_gate = dma_q & ~svc_flag;
    assign reg_rdata    = {mode_q, fdis_q, dma_q, svc_flag, fifo_full, fifo_empty};

    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R4
    gate_off_after_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_irq && !$past(reg_wr)) |-> !dma_req_gate);
endmodule

// File: tb/ppx_ctl_reg_tb_top.sv
module ppx_ctl_reg_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [CW-1:0] fifo_level = '0;
    logic          dir_in = 1'b0;
    logic [CW-1:0] wr_thresh = CW'(4);
    logic [CW-1:0] rd_thresh = CW'(8);
    logic          tc_pulse = 1'b0;
    logic          fault_n = 1'b1;
    logic [2:0]    mode_sel;
    logic          dma_en, dma_req_gate, svc_irq, fault_irq, fifo_full, fifo_empty;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int svc_cnt, flt_cnt;

    always #(CLK_P/2) clk = ~clk;

    ppx_ctl_reg #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_level(fifo_level), .dir_in(dir_in),
        .wr_thresh(wr_thresh), .rd_thresh(rd_thresh), .tc_pulse(tc_pulse),
        .fault_n(fault_n), .mode_sel(mode_sel), .dma_en(dma_en),
        .dma_req_gate(dma_req_gate), .svc_irq(svc_irq), .fault_irq(fault_irq),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic count_win(input int n);
        svc_cnt = 0;
        flt_cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (svc_irq) svc_cnt++;
            if (fault_irq) flt_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 rdata", reg_rdata, 8'h05);
        chk("R1 irq", {svc_irq, fault_irq}, 0);
        chk("R4 gate at reset", {dma_en, dma_req_gate}, 0);
    endtask

    task automatic t_mode_status();
        wr_reg(8'hE4); #1;
        chk("R2 mode_sel", mode_sel, 7);
        chk("R2 rdata", reg_rdata, 8'hE5);
        wr_reg(8'h27); #1;
        chk("R3 ro bits empty", reg_rdata, 8'h25);
        fifo_level = CW'(DEPTH); #1;
        chk("R3 full", reg_rdata, 8'h26);
        chk("R3 full pin", {fifo_full, fifo_empty}, 2'b10);
        fifo_level = CW'(5); #1;
        chk("R3 neither", reg_rdata, 8'h24);
    endtask

    task automatic t_dma();
        fifo_level = CW'(5);
        wr_reg(8'h0C); #1;
        chk("R4 enabled masked", {dma_en, dma_req_gate}, 2'b10);
        wr_reg(8'h08); #1;
        chk("R4 gate open", {dma_en, dma_req_gate}, 2'b11);
        count_win(3);
        chk("R7 no tc no irq", svc_cnt, 0);
        @(negedge clk); tc_pulse = 1'b1;
        @(negedge clk); tc_pulse = 1'b0;
        count_win(4);
        chk("R7 R11 one pulse", svc_cnt, 1);
        chk("R7 flag set", reg_rdata[2], 1);
        chk("R4 gate closed", dma_req_gate, 0);
        @(negedge clk); tc_pulse = 1'b1;
        @(negedge clk); tc_pulse = 1'b0;
        count_win(4);
        chk("R10 masked tc", svc_cnt, 0);
    endtask

    task automatic t_out_thresh();
        dir_in = 1'b0; wr_thresh = CW'(4); fifo_level = CW'(14);
        wr_reg(8'h00);
        count_win(4);
        chk("R8 below thresh", svc_cnt, 0);
        chk("R8 flag clear", reg_rdata[2], 0);
        fifo_level = CW'(12);
        count_win(4);
        chk("R8 at thresh", svc_cnt, 1);
        chk("R8 flag set", reg_rdata[2], 1);
        wr_reg(8'h04);
        count_win(4);
        chk("R10 write one no irq", svc_cnt, 0);
    endtask

    task automatic t_in_thresh();
        dir_in = 1'b1; rd_thresh = CW'(8); fifo_level = CW'(7);
        wr_reg(8'h00);
        count_win(4);
        chk("R9 below thresh", svc_cnt, 0);
        fifo_level = CW'(8);
        count_win(4);
        chk("R9 at thresh", svc_cnt, 1);
        dir_in = 1'b0; fifo_level = CW'(14);
    endtask

    task automatic fall_and_count(output int c);
        @(negedge clk); fault_n = 1'b0;
        count_win(6);
        c = flt_cnt;
        fault_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_fault_edge();
        int c;
        wr_reg(8'h64);
        fall_and_count(c);
        chk("R5 R11 ecp edge", c, 1);
        wr_reg(8'h74);
        fall_and_count(c);
        chk("R5 disabled", c, 0);
        wr_reg(8'h24);
        fall_and_count(c);
        chk("R5 other mode", c, 0);
    endtask

    task automatic t_fault_clear();
        wr_reg(8'h74);
        @(negedge clk); fault_n = 1'b0;
        repeat (6) @(negedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h64;
        @(negedge clk); reg_wr = 1'b0;
        count_win(4);
        chk("R6 clear while low", flt_cnt, 1);
        wr_reg(8'h64);
        count_win(4);
        chk("R6 zero over zero", flt_cnt, 0);
        fault_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode_status();
        t_dma();
        t_out_thresh();
        t_in_thresh();
        t_fault_edge();
        t_fault_clear();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule